// File: doc/BRIEF.md
# Receiver Error Logger with Audio Sample Hold

This block sits behind the decoder of a digital audio interface receiver. For every decoded subframe it receives the audio sample, the channel it belongs to and seven error flags. These flags are lock loss, validity, low eye confidence, bi-phase coding error, parity error, Q-subcode CRC error and channel-status CRC error. A host-programmed mask decides which of these flags count.

Only counted errors are logged. Each one sets a bit in a sticky register, which stays set until the host reads it. Each counted error also pulses an error pin, and the interrupt line stays high while anything is logged.

The same counted errors apply a selectable hold policy to the outgoing sample. The policy can repeat the last clean sample of that channel, output zero, or pass the sample through. The two CRC flags are logged but never change the audio. The host register bus is reduced to a parallel view of the sticky register and a one-cycle read strobe that clears it.

Top module: `rx_err_hold`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_valid`, `out_data`, `err_reg`, `err_pin` and `irq` are all zero.
- R2: Flag bit positions are: 0 lock loss, 1 validity, 2 confidence, 3 bi-phase, 4 parity, 5 Q-subcode CRC, 6 channel-status CRC. When a subframe is accepted (`sf_valid` high), every flag whose mask bit is 1 sets the same bit of `err_reg` on the next cycle.
- R3: A bit of `err_reg` stays set until a cycle with `rd_strobe` high. That cycle clears the register on the following edge, except for bits set by an accepted subframe in the same cycle, which remain set.
- R4: A flag whose mask bit is 0 sets no bit of `err_reg`, causes no `err_pin` pulse and leaves the sample untouched.
- R5: `err_pin` is high for exactly the one cycle in which `out_valid` presents a subframe that carried at least one unmasked flag, and low otherwise.
- R6: `irq` is high exactly when `err_reg` is nonzero.
- R7: With `hold_mode` = 1, a subframe with an unmasked audio-affecting flag (bits 0 to 4) outputs the last sample of the same channel that was output without substitution. Channels A (`sf_chan`=0) and B (`sf_chan`=1) are tracked separately, and the value is 0 after reset.
- R8: With `hold_mode` = 2, a subframe with an unmasked audio-affecting flag outputs zero.
- R9: With `hold_mode` = 0 or 3, the sample is passed unchanged even when audio-affecting flags are unmasked.
- R10: Flags 5 and 6 never alter the output sample, even when unmasked.
- R11: `out_valid`, `out_chan` and `out_data` appear one cycle after the `sf_valid` cycle. `out_valid` is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Subframe present this cycle |
| sf_chan | input | 1 | Channel of the subframe (0 = A, 1 = B) |
| sf_data | input | DW | Decoded audio sample |
| err_flags | input | 7 | Error flags of the subframe |
| err_mask | input | 7 | 1 = error counted, 0 = ignored |
| hold_mode | input | 2 | 0/3 pass, 1 repeat previous, 2 zero |
| rd_strobe | input | 1 | Host read of the error register (clears it) |
| out_valid | output | 1 | Output sample present |
| out_chan | output | 1 | Channel of the output sample |
| out_data | output | DW | Output sample after hold policy |
| err_reg | output | 7 | Sticky error register |
| err_pin | output | 1 | One-cycle pulse per erroneous subframe |
| irq | output | 1 | Interrupt, high while any error is logged |

## Verification
The embedded properties check several rules on every cycle. Logged bits never drop without a read, and the pin fires only alongside an output subframe that had an unmasked flag. Zero substitution and CRC transparency are held, and the output follows its input by exactly one cycle. Some behaviour depends on history, and only the bench scenarios can show it. This includes per-channel tracking of the last clean sample, the order of read clearing against a simultaneous new error, masked flags leaving the register untouched, and the pass-through codes.

// File: rtl/rx_err_hold.sv
module rx_err_hold #(
  parameter int DW = 24,
  parameter int NE = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sf_valid,
  input  logic          sf_chan,
  input  logic [DW-1:0] sf_data,
  input  logic [NE-1:0] err_flags,
  input  logic [NE-1:0] err_mask,
  input  logic [1:0]    hold_mode,
  input  logic          rd_strobe,
  output logic          out_valid,
  output logic          out_chan,
  output logic [DW-1:0] out_data,
  output logic [NE-1:0] err_reg,
  output logic          err_pin,
  output logic          irq
);

  localparam logic [NE-1:0] AUDIO_BITS = NE'(7'h1F);

  logic [NE-1:0] live;
  logic          hit_audio;
  logic          do_rep, do_zero;
  logic [DW-1:0] last_a, last_b, last_sel, next_data;

  assign live      = err_flags & err_mask;
  assign hit_audio = |(live & AUDIO_BITS);
  assign do_rep    = hit_audio && hold_mode == 2'd1;
  assign do_zero   = hit_audio && hold_mode == 2'd2;
  assign last_sel  = sf_chan ? last_b : last_a;
  assign next_data = do_zero ? '0 : (do_rep ? last_sel : sf_data);
  assign irq       = |err_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
      err_reg   <= '0;
      err_pin   <= 1'b0;
      last_a    <= '0;
      last_b    <= '0;
    end else begin
      out_valid <= sf_valid;
      err_pin   <= sf_valid && |live;
      err_reg   <= (rd_strobe ? '0 : err_reg) | (sf_valid ? live : '0);
      if (sf_valid) begin
        out_chan <= sf_chan;
        out_data <= next_data;
        if (!do_rep && !do_zero) begin
          if (sf_chan) last_b <= sf_data;
          else         last_a <= sf_data;
        end
      end
    end
  end

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_strobe) |-> ((~err_reg & $past(err_reg)) == '0));

  // R5
  pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pin |-> ($past(sf_valid) && ($past(err_flags & err_mask) != '0)));

  // R8
  zero_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sf_valid) && $past(hold_mode) == 2'd2 &&
     ($past(err_flags & err_mask) & AUDIO_BITS) != '0) |-> out_data == '0);

  // R10
  crc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sf_valid) && ($past(err_flags & err_mask) & AUDIO_BITS) == '0)
      |-> out_data == $past(sf_data));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(sf_valid));

endmodule

// File: tb/tb_rx_err_hold.sv
module tb_rx_err_hold;
  localparam int DW = 24;
  localparam int NV = 12;

  logic clk = 0, rst_n = 0;
  logic sf_valid = 0, sf_chan = 0, rd_strobe = 0;
  logic [DW-1:0] sf_data = '0;
  logic [6:0] err_flags = '0, err_mask = '0;
  logic [1:0] hold_mode = '0;
  logic out_valid, out_chan, err_pin, irq;
  logic [DW-1:0] out_data;
  logic [6:0] err_reg;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  rx_err_hold #(.DW(DW), .NE(7)) dut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_data(sf_data), .err_flags(err_flags), .err_mask(err_mask),
    .hold_mode(hold_mode), .rd_strobe(rd_strobe), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data), .err_reg(err_reg),
    .err_pin(err_pin), .irq(irq));

  // {chan, data, flags, mask, mode, expected data, expected pin}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 24'h111111, 7'h00, 7'h7F, 2'd1, 24'h111111, 1'b0},
    {1'b1, 24'h222222, 7'h00, 7'h7F, 2'd1, 24'h222222, 1'b0},
    {1'b0, 24'h333333, 7'h01, 7'h7F, 2'd1, 24'h111111, 1'b1},
    {1'b1, 24'h444444, 7'h10, 7'h7F, 2'd2, 24'h000000, 1'b1},
    {1'b0, 24'h555555, 7'h08, 7'h7F, 2'd0, 24'h555555, 1'b1},
    {1'b1, 24'h666666, 7'h20, 7'h7F, 2'd1, 24'h666666, 1'b1},
    {1'b0, 24'h777777, 7'h40, 7'h7F, 2'd2, 24'h777777, 1'b1},
    {1'b0, 24'h888888, 7'h04, 7'h7B, 2'd1, 24'h888888, 1'b0},
    {1'b1, 24'h999999, 7'h02, 7'h7F, 2'd1, 24'h666666, 1'b1},
    {1'b0, 24'hAAAAAA, 7'h1F, 7'h00, 2'd2, 24'hAAAAAA, 1'b0},
    {1'b0, 24'hBBBBBB, 7'h04, 7'h7F, 2'd1, 24'hAAAAAA, 1'b1},
    {1'b1, 24'hCCCCCC, 7'h01, 7'h7F, 2'd3, 24'hCCCCCC, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic ch, input logic [DW-1:0] d, input logic [6:0] f,
                      input logic [6:0] m, input logic [1:0] md, input logic rd);
    @(negedge clk);
    sf_valid = 1; sf_chan = ch; sf_data = d; err_flags = f;
    err_mask = m; hold_mode = md; rd_strobe = rd;
    @(negedge clk);
    sf_valid = 0; rd_strobe = 0; err_flags = '0;
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 out_data", 32'(out_data), 0);
    check("R1 err_reg", 32'(err_reg), 0);
    check("R1 err_pin/irq", {30'd0, err_pin, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {7'd0, err_reg, err_pin, irq, out_valid, out_data[DW-1:8]}, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][65], VEC[i][64:41], VEC[i][40:34], VEC[i][33:27], VEC[i][26:25], 0);
      // R7 R8 R9 R10 R4 sample policy, R11 latency, R5 pin
      check($sformatf("R7/R8/R9/R10 data v%0d", i), 32'(out_data), 32'(VEC[i][24:1]));
      check($sformatf("R11 valid/chan v%0d", i), {30'd0, out_valid, out_chan}, {30'd0, 1'b1, VEC[i][65]});
      check($sformatf("R5 pin v%0d", i), 32'(err_pin), 32'(VEC[i][0]));
    end
    @(negedge clk);
    check("R5 pin single cycle", 32'(err_pin), 0);
    check("R11 valid drops", 32'(out_valid), 0);
    // R2 accumulated bits across vectors, R4 masked ones included elsewhere
    check("R2 err_reg accumulated", 32'(err_reg), 32'h7F);
    check("R6 irq set", 32'(irq), 1);
    repeat (3) @(negedge clk);
    check("R3 sticky while idle", 32'(err_reg), 32'h7F);

    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    check("R3 read clears", 32'(err_reg), 0);
    check("R6 irq clear", 32'(irq), 0);

    // R3 set wins over clear
    send(0, 24'h010203, 7'h08, 7'h7F, 2'd0, 1);
    check("R3 set wins", 32'(err_reg), 32'h08);

    // R4 masked flag leaves register, pin and data untouched
    send(1, 24'h0A0B0C, 7'h10, 7'h6F, 2'd2, 0);
    check("R4 reg unchanged", 32'(err_reg), 32'h08);
    check("R4 no pin", 32'(err_pin), 0);
    check("R4 data passed", 32'(out_data), 32'h0A0B0C);

    // R2 single bit position: channel-status CRC sets bit 6 only
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    send(1, 24'h123456, 7'h40, 7'h7F, 2'd1, 0);
    check("R2 bit6 position", 32'(err_reg), 32'h40);
    check("R10 crc sample", 32'(out_data), 32'h123456);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule